// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block is the device side of a small serial EEPROM that stores 16-bit words. A host selects it with an active-low select, clocks command frames in on a serial data line, and reads words back on a data output whose enable is modelled as a separate signal. All serial inputs are sampled with the system clock, so the block sees serial clock edges as level changes between consecutive system cycles.

Every frame begins with a start bit, followed by a command code and, for memory commands, an address. Addresses and data move least-significant bit first. A read streams the addressed word and then the following ones for as long as the host keeps clocking. A write shifts in one data word and then runs a self-timed programming cycle, counted in system clocks, with a ready/busy output. A write-control input cancels a programming cycle that is already running. Writes only take effect after an enable frame.

Top module: `eep_serial_slave`

## Requirements
- R1: The data input is taken only on serial clock rising edges. The data output changes only after serial clock falling edges, or when the ready level it is showing changes.
- R2: Frame layout, counting serial clock rises from the start bit: clock 1 is a start bit of 1, and any zeros received before it are skipped. Clocks 2 and 3 carry the command: 1,0 is read; 0,1 is write; 0,0 is control; 1,1 is ignored until select rises. For memory commands the address arrives LSB first on clocks 9 to 16 (ADDR_W = 8).
- R3: Raising select abandons a frame in progress, returns to idle and removes the output enable in the following cycle, except during a programming cycle.
- R4: After reset the block is write-disabled, ready/busy is high, the output enable is low, and word i holds INIT_KEY XOR i.
- R5: A control frame is complete after clock 16. Clocks 4 and 5 both 1 enable writes, both 0 disable writes, and any other pair changes nothing. Extra clocks before select rises are ignored. A write sent while writes are disabled leaves memory unchanged.
- R6: A read drives bit 0 of the addressed word after the falling edge following clock 16. Each later fall gives the next bit. Every 16 falls, the next address is output, wrapping from the top address to 0.
- R7: A write takes data LSB first on clocks 17 to 32. The rise of clock 32 starts programming, which holds ready/busy low for PROG_CYCLES system clocks and then stores the word and sets ready/busy high.
- R8: While ready/busy is low, no frame is decoded. A control frame sent then has no effect on the write-enable state.
- R9: Write-control high during programming ends the cycle at once, whatever the level of select, and ready/busy is high the following cycle. At any other time write-control has no effect.
- R10: An abort with fewer than PROG_CYCLES/2 elapsed clocks leaves the target word unchanged. A later abort stores the bitwise inverse of the written data.
- R11: Once a write has started programming, a fall of select while the serial clock is low puts the ready/busy level on the data output with the output enabled. This holds until select rises or a new start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| wrLock | input | 1 | Write-control; high cancels programming |
| sdo | output | 1 | Serial data out (read data or ready level) |
| sdoEn | output | 1 | Output enable for sdo; low means high impedance |
| rdyBusy | output | 1 | High when ready, low while programming |

## Verification
Reads are run with leading zeros before the start bit, across several words, and across the top-address wrap. This separates a correct start search and address increment from a fixed-length or non-wrapping frame. Writes are sent while disabled, while enabled, abandoned part way through, and cancelled early and late. The read-back word shows whether the commit, the ignore path and the midpoint rule each picked the right content. Status display, a control frame sent during busy, an invalid command, and write-control held during reads separate the command gating from the programming timer. A behavioural model predicts the enable, data and ready levels on every cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  // Clocks in a command header, start bit included
  localparam int HDR_LEN = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RDATA,
    ST_WDATA,
    ST_DONE,
    ST_PROG
  } eepState_t;

  typedef struct packed {
    logic hdrShift;
    logic addrLatch;
    logic dataShift;
    logic rdLoad;
    logic rdShift;
    logic commitGood;
    logic commitBad;
  } eepStrobe_t;
endpackage

// File: rtl/eep_dpath.sv
module eep_dpath
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] INIT_KEY = 16'hC3A5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdi,
  input  eepStrobe_t strb,
  output logic [3:0] cmdBits,
  output logic       readBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HW = HDR_LEN - 1;

  logic [HW-2:0]     hdrReg;
  logic [HW-1:0]     hdrNext;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] mem [DEPTH];

  // Header bits after the start bit; index 0 is clock 2
  assign hdrNext = {sdi, hdrReg};
  assign cmdBits = hdrNext[3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg   <= '0;
      addrReg  <= '0;
      dataReg  <= '0;
      outShift <= '0;
      readBit  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_KEY ^ DATA_W'(i);
    end else begin
      if (strb.hdrShift) hdrReg <= hdrNext[HW-1:1];
      if (strb.addrLatch) addrReg <= hdrNext[HW-1 -: ADDR_W];
      if (strb.dataShift) dataReg <= {sdi, dataReg[DATA_W-1:1]};
      if (strb.rdLoad) begin
        readBit  <= mem[addrReg][0];
        outShift <= {1'b0, mem[addrReg][DATA_W-1:1]};
        addrReg  <= addrReg + 1'b1;
      end else if (strb.rdShift) begin
        readBit  <= outShift[0];
        outShift <= {1'b0, outShift[DATA_W-1:1]};
      end
      if (strb.commitGood) mem[addrReg] <= dataReg;
      else if (strb.commitBad) mem[addrReg] <= ~dataReg;
    end
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       wrLock,
  input  logic [3:0] cmdBits,
  output eepStrobe_t strb,
  output logic       ready,
  output logic       showStatus,
  output logic       readDrive
);
  localparam int CNT_W = $clog2(HDR_LEN > DATA_W ? HDR_LEN : DATA_W);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_LEN - 2);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [PW-1:0] PROG_LOAD = PW'(PROG_CYCLES - 1);
  localparam logic [PW-1:0] LATE_MAX  = PW'(PROG_CYCLES - 1 - PROG_CYCLES / 2);

  eepState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic [PW-1:0]    progCnt;
  logic             sclkQ, selNQ, writeEn, armed;
  logic             skRise, skFall, selFall;

  assign skRise  = sclk & ~sclkQ;
  assign skFall  = ~sclk & sclkQ;
  assign selFall = ~selN & selNQ;
  assign ready   = (state != ST_PROG);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_HDR: begin
        strb.hdrShift  = !selN && skRise;
        strb.addrLatch = !selN && skRise && (bitCnt == HDR_LAST);
      end
      ST_RDATA: begin
        strb.rdLoad  = !selN && skFall && (bitCnt == '0);
        strb.rdShift = !selN && skFall && (bitCnt != '0);
      end
      ST_WDATA: strb.dataShift = !selN && skRise;
      ST_PROG: begin
        strb.commitBad  = wrLock && (progCnt <= LATE_MAX);
        strb.commitGood = !wrLock && (progCnt == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      progCnt    <= '0;
      sclkQ      <= 1'b0;
      selNQ      <= 1'b1;
      writeEn    <= 1'b0;
      armed      <= 1'b0;
      showStatus <= 1'b0;
      readDrive  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      selNQ <= selN;
      if (selN) showStatus <= 1'b0;
      else if (selFall && !sclk && armed) showStatus <= 1'b1;

      if (state == ST_PROG) begin
        if (wrLock || progCnt == '0) state <= selN ? ST_IDLE : ST_DONE;
        else progCnt <= progCnt - 1'b1;
      end else if (selN) begin
        state     <= ST_IDLE;
        readDrive <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (skRise && sdi) begin
            state      <= ST_HDR;
            bitCnt     <= '0;
            armed      <= 1'b0;
            showStatus <= 1'b0;
          end
          ST_HDR: if (skRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == HDR_LAST) begin
              bitCnt <= '0;
              unique case (cmdBits[1:0])
                2'b01: state <= ST_RDATA;
                2'b10: state <= ST_WDATA;
                2'b00: begin
                  state <= ST_DONE;
                  if (cmdBits[3:2] == 2'b11) writeEn <= 1'b1;
                  else if (cmdBits[3:2] == 2'b00) writeEn <= 1'b0;
                end
                default: state <= ST_DONE;
              endcase
            end
          end
          ST_RDATA: if (skFall) begin
            readDrive <= 1'b1;
            bitCnt    <= (bitCnt == DATA_LAST) ? '0 : bitCnt + 1'b1;
          end
          ST_WDATA: if (skRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == DATA_LAST) begin
              bitCnt <= '0;
              if (writeEn) begin
                state   <= ST_PROG;
                progCnt <= PROG_LOAD;
                armed   <= 1'b1;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PROG_CYCLES = 64,
  parameter logic [DATA_W-1:0] INIT_KEY = 16'hC3A5
) (
  input  logic clk,
  input  logic rstN,
  input  logic selN,
  input  logic sclk,
  input  logic sdi,
  input  logic wrLock,
  output logic sdo,
  output logic sdoEn,
  output logic rdyBusy
);
  eepStrobe_t strb;
  logic [3:0] cmdBits;
  logic       readBit, ready, showStatus, readDrive;

  eep_ctrl #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .wrLock(wrLock), .cmdBits(cmdBits), .strb(strb), .ready(ready),
    .showStatus(showStatus), .readDrive(readDrive)
  );

  eep_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_KEY(INIT_KEY)) u_dpath (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb),
    .cmdBits(cmdBits), .readBit(readBit)
  );

  assign sdo     = showStatus ? ready : readBit;
  assign sdoEn   = showStatus | readDrive;
  assign rdyBusy = ready;
endmodule

// File: rtl/eep_serial_slave_chk.sv
module eep_serial_slave_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic sclk,
  input logic wrLock,
  input logic sdo,
  input logic sdoEn,
  input logic rdyBusy
);
  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else busyRun <= rdyBusy ? '0 : busyRun + 1'b1;
  end

  // R1: enabled output moves only after a serial fall or a ready change
  assert_out_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && (sdo != $past(sdo))) |->
    (($past(sclk, 2) && !$past(sclk)) || (rdyBusy != $past(rdyBusy))));

  // R3: deselect drops the output enable
  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> !sdoEn);

  // R7: busy starts only on a selected serial rise
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusy) |-> ($past(sclk) && !$past(sclk, 2) && !$past(selN)));

  // R7: busy never outlasts the programming time
  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 32'(PROG_CYCLES));

  // R9: write-control ends programming in one cycle
  assert_abort_now_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBusy && wrLock) |=> rdyBusy);

  // R11: while busy, an enabled output shows the busy level
  assert_status_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBusy && sdoEn) |-> !sdo);
endmodule

bind eep_serial_slave eep_serial_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .wrLock(wrLock),
  .sdo(sdo), .sdoEn(sdoEn), .rdyBusy(rdyBusy)
);

// File: tb/sim_eep_serial_slave.sv
`timescale 1ns/1ps
module sim_eep_serial_slave;
  localparam int P = 40;
  localparam int NW = 256;
  localparam logic [15:0] KEY = 16'hC3A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, sclk = 1'b0, sdi = 1'b0, wrLock = 1'b0;
  logic sdo, sdoEn, rdyBusy;

  int vectors = 0, miss = 0;
  bit done = 0;
  string curReq = "R4 reset";

  // model state
  logic expEn, expDo, expRdy;
  int mMem [NW];
  bit mSclk, mSel, mWe, mArm, mShow, mOutEn, mOut;
  int mBusy, mElapsed, mPhase, nClk, mHdr, mAddr, mData, mWord;

  always #2 clk = ~clk;

  eep_serial_slave #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(P), .INIT_KEY(KEY)) u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .wrLock(wrLock), .sdo(sdo), .sdoEn(sdoEn), .rdyBusy(rdyBusy)
  );

  // Behavioural reference, advanced once per system clock
  always @(posedge clk) begin
    bit rise, fall, selFall;
    if (!rstN) begin
      for (int i = 0; i < NW; i++) mMem[i] = int'(KEY) ^ i;
      mSclk = 0; mSel = 1; mWe = 0; mArm = 0; mShow = 0; mOutEn = 0; mOut = 0;
      mBusy = 0; mElapsed = 0; mPhase = 0; nClk = 0; mHdr = 0; mAddr = 0;
      mData = 0; mWord = 0;
    end else begin
      rise = sclk && !mSclk;
      fall = !sclk && mSclk;
      selFall = !selN && mSel;
      if (selN) mShow = 0;
      else if (selFall && !sclk && mArm) mShow = 1;
      if (mBusy > 0) begin
        if (wrLock) begin
          if (mElapsed >= P / 2) mMem[mAddr] = (~mData) & 16'hFFFF;
          mBusy = 0;
          mPhase = selN ? 0 : 4;
        end else begin
          mElapsed++;
          mBusy--;
          if (mBusy == 0) begin
            mMem[mAddr] = mData;
            mPhase = selN ? 0 : 4;
          end
        end
      end else if (selN) begin
        mPhase = 0;
        mOutEn = 0;
      end else begin
        case (mPhase)
          0: if (rise && sdi) begin
            mPhase = 1; nClk = 1; mHdr = 0; mArm = 0; mShow = 0;
          end
          1: if (rise) begin
            mHdr = mHdr | (int'(sdi) << nClk);
            nClk++;
            if (nClk == 16) begin
              mAddr = (mHdr >> 8) & 255;
              nClk = 0;
              if (mHdr[1] && !mHdr[2]) mPhase = 2;
              else if (!mHdr[1] && mHdr[2]) begin mPhase = 3; mData = 0; end
              else begin
                mPhase = 4;
                if (!mHdr[1] && !mHdr[2]) begin
                  if (mHdr[3] && mHdr[4]) mWe = 1;
                  else if (!mHdr[3] && !mHdr[4]) mWe = 0;
                end
              end
            end
          end
          2: if (fall) begin
            mOutEn = 1;
            if (nClk % 16 == 0) begin
              mWord = mMem[mAddr];
              mAddr = (mAddr + 1) % NW;
            end
            mOut = mWord[nClk % 16];
            nClk++;
          end
          3: if (rise) begin
            mData = mData | (int'(sdi) << nClk);
            nClk++;
            if (nClk == 16) begin
              if (mWe) begin mBusy = P; mElapsed = 0; mArm = 1; end
              else mPhase = 4;
            end
          end
          default: ;
        endcase
      end
      mSclk = sclk;
      mSel = selN;
    end
    expRdy = (mBusy == 0);
    expEn = mOutEn || mShow;
    expDo = mShow ? expRdy : mOut;
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      vectors++;
      if (sdoEn !== expEn || rdyBusy !== expRdy || (expEn && sdo !== expDo)) begin
        miss++;
        $display("FAIL %s t=%0t: en/do/rdy actual %b/%b/%b expected %b/%b/%b",
                 curReq, $time, sdoEn, sdo, rdyBusy, expEn, expDo, expRdy);
      end
    end
  end

  task automatic tick(input logic s, input logic k, input logic d);
    @(negedge clk);
    selN = s; sclk = k; sdi = d;
  endtask

  task automatic setWc(input logic v);
    @(negedge clk);
    wrLock = v;
  endtask

  task automatic sendBit(input logic d);
    tick(1'b0, 1'b0, d);
    tick(1'b0, 1'b1, d);
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) tick(selN, 1'b0, 1'b0);
  endtask

  task automatic desel();
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
  endtask

  function automatic logic [15:0] makeHdr(input logic c2, input logic c3,
                                          input logic s4, input logic s5,
                                          input logic [7:0] a);
    logic [15:0] h;
    h = '0;
    h[0] = 1'b1; h[1] = c2; h[2] = c3; h[3] = s4; h[4] = s5;
    h[15:8] = a;
    return h;
  endfunction

  task automatic sendWord(input logic [15:0] v);
    for (int i = 0; i < 16; i++) sendBit(v[i]);
  endtask

  task automatic doRead(input logic [7:0] a, input int n);
    sendWord(makeHdr(1'b1, 1'b0, 1'b0, 1'b0, a));
    for (int i = 0; i < 16 * n; i++) sendBit(1'b0);
    desel();
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] v);
    sendWord(makeHdr(1'b0, 1'b1, 1'b0, 1'b0, a));
    sendWord(v);
    tick(1'b1, 1'b0, 1'b0);
  endtask

  task automatic ctrlFrame(input logic s4, input logic s5);
    sendWord(makeHdr(1'b0, 1'b0, s4, s5, 8'h00));
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    desel();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    hold(3);

    curReq = "R2 R6 read with leading zeros, two words";
    tick(1'b0, 1'b0, 1'b0);
    sendBit(1'b0); sendBit(1'b0);
    doRead(8'd5, 2);

    curReq = "R5 write while disabled";
    doWrite(8'd5, 16'h1234);
    hold(P + 4);
    doRead(8'd5, 1);

    curReq = "R5 enable with trailing clocks";
    ctrlFrame(1'b1, 1'b1);

    curReq = "R7 write then read back";
    doWrite(8'd5, 16'h1234);
    hold(P + 4);
    doRead(8'd5, 1);

    curReq = "R6 sequential read across top wrap";
    doRead(8'd255, 2);

    curReq = "R11 status on output after write";
    doWrite(8'd7, 16'hBEEF);
    tick(1'b0, 1'b0, 1'b0);
    hold(P + 4);
    desel();

    curReq = "R8 control frame during busy is ignored";
    doWrite(8'd8, 16'h0F0F);
    sendWord(makeHdr(1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    hold(P);
    desel();
    doWrite(8'd9, 16'h5555);
    hold(P + 4);
    doRead(8'd8, 2);

    curReq = "R9 R10 early abort with select high";
    doWrite(8'd10, 16'hA0A0);
    hold(1);
    setWc(1'b1); setWc(1'b0);
    hold(4);
    doRead(8'd10, 1);

    curReq = "R10 late abort stores inverse";
    doWrite(8'd11, 16'h3C01);
    hold(27);
    setWc(1'b1); setWc(1'b0);
    hold(4);
    doRead(8'd11, 1);

    curReq = "R9 write-control during read and control frames";
    setWc(1'b1);
    doRead(8'd9, 1);
    ctrlFrame(1'b1, 1'b1);
    setWc(1'b0);

    curReq = "R3 abandoned write frame";
    sendWord(makeHdr(1'b0, 1'b1, 1'b0, 1'b0, 8'd12));
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    desel();
    hold(P);
    doRead(8'd12, 1);

    curReq = "R2 invalid command code";
    sendWord(makeHdr(1'b1, 1'b1, 1'b0, 1'b0, 8'd13));
    for (int i = 0; i < 16; i++) sendBit(1'b1);
    desel();

    curReq = "R5 disable then write ignored";
    ctrlFrame(1'b0, 1'b0);
    doWrite(8'd14, 16'hFFFF);
    hold(P + 4);
    doRead(8'd14, 1);

    curReq = "R1 final idle";
    hold(8);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      miss++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule